// File: doc/BRIEF.md
# Watchdog Timer with Keyed Register Access

This block is a watchdog peripheral that sits on a simple 32-bit register bus. Software loads a reload value, enables the timer, and must then service it often enough by writing a fixed restart key. A 32-bit down-counter is loaded from the reload register and steps down on qualified ticks. If it reaches zero while running, the block stops counting and emits a reset-request pulse. The pulse has a programmable width and polarity.

A separate width register holds the pulse length in its low bits. Two further bits, for polarity and drive type, change only when a key byte arrives in the top byte of a write. A suppress input lets the surrounding system cancel an expiry. When suppress is high at expiry, no pulse is issued and the control register is wiped instead.

The bus is single-cycle. Writes take effect at the next clock edge. Read data is combinational from the current address.

Top module: `wdog_top`

## Requirements
- R1: After reset, the counter (offset 0x00) and the reload register (0x04) read 0x03EF1480, control (0x0C) reads 0, the width register (0x18) reads 0x000000FF, and the reset-request output is idle high, because bit 31 of the width register is 0 (active-low).
- R2: Byte offsets are 0x00 counter (read-only), 0x04 reload, 0x08 restart (write-only), 0x0C control, 0x18 width and 0x1C mask.
  - Reads of 0x08 and of any undefined offset return 0.
  - Writes to 0x00 or to an undefined offset change nothing.
- R3: A write to 0x08 whose bits [15:0] equal 0x4755 copies the reload value into the counter. If control bit 0 is set, the counter also runs. A write with any other value changes nothing.
- R4: A control write stores the data with bits [11:8] forced to 0 and bit 4 (1 MHz tick select) forced to 1. Bit 0 is enable.
- R5: A control write that takes bit 0 from 0 to 1 loads the counter from reload and starts it. A write that takes bit 0 from 1 to 0 stops the counter, which then holds its value. Any other control write only updates the register.
- R6: While running, the counter decreases by one at each clock edge where tickEn is high. Offset 0x00 reads the live count.
- R7: A running counter found at zero stops at that clock edge and starts an active reset pulse that lasts exactly (width[19:0] + 1) cycles. A restart-key or control write in that same cycle still decides the counter, the run state and the control value.
- R8: If suppressReset is high at expiry, no pulse starts and the control register becomes 0.
- R9: A width write stores bits [19:0] of the data; bits [29:20] read 0. The data's top byte acts as a key:
  - 0xA5 sets bit 31 and 0x5A clears it.
  - 0xA8 sets bit 30 and 0x8A clears it.
  - Any other top byte leaves bits 31 and 30 unchanged.
- R10: resetReq equals the pulse when width bit 31 is 1 (active-high). It is the inverse of the pulse when bit 31 is 0.
- R11: The mask register at 0x1C stores and returns all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address (combinational) |
| tickEn | input | 1 | Count qualifier; the counter steps on cycles where this is high |
| suppressReset | input | 1 | Cancels the reset pulse at expiry and clears control |
| resetReq | output | 1 | Reset request at the programmed polarity |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 20-bit pulse width and the documented reset values. With those defaults the R1 values can be read back directly. Expiry is reached within a few cycles by writing small reload values at run time, and pulse widths are kept below eight cycles. Under these settings, back-to-back expiries, pulses restarted mid-flight, suppressed expiries and polarity flips during a pulse all occur often within a short random run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFF_COUNT  = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h04;
  localparam logic [7:0] OFF_KICK   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_WIDTH  = 8'h18;
  localparam logic [7:0] OFF_MASK   = 8'h1C;

  localparam logic [15:0] KICK_KEY = 16'h4755;

  localparam logic [7:0] KEY_POL_HIGH  = 8'hA5;
  localparam logic [7:0] KEY_POL_LOW   = 8'h5A;
  localparam logic [7:0] KEY_DRV_PUSH  = 8'hA8;
  localparam logic [7:0] KEY_DRV_OPEN  = 8'h8A;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_TICK_BIT = 4;
  localparam int unsigned POL_BIT       = 31;
  localparam int unsigned DRV_BIT       = 30;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_COUNT, SEL_RELOAD, SEL_CTRL, SEL_WIDTH, SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic wrReload;
    logic kick;
    logic wrCtrl;
    logic wrWidth;
    logic wrMask;
  } strobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       kickData,
  output strobes_t          stb,
  output rdSel_e            rdSel
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_WIDTH  = ADDR_W'(OFF_WIDTH);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    if (busValid && busWrite) begin
      case (busAddr)
        A_RELOAD: stb.wrReload = 1'b1;
        A_KICK:   stb.kick     = (kickData == KICK_KEY);
        A_CTRL:   stb.wrCtrl   = 1'b1;
        A_WIDTH:  stb.wrWidth  = 1'b1;
        A_MASK:   stb.wrMask   = 1'b1;
        default:  ;
      endcase
    end else if (busValid) begin
      case (busAddr)
        A_COUNT:  rdSel = SEL_COUNT;
        A_RELOAD: rdSel = SEL_RELOAD;
        A_CTRL:   rdSel = SEL_CTRL;
        A_WIDTH:  rdSel = SEL_WIDTH;
        A_MASK:   rdSel = SEL_MASK;
        default:  rdSel = SEL_NONE;
      endcase
    end
  end

  // R2: at most one register strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // R2: reads never raise a write strobe
  p_read_no_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |-> (stb == '0));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int unsigned       PULSE_W    = 20,
  parameter logic [WORD_W-1:0] INIT_COUNT = 32'h03EF_1480,
  parameter logic [WORD_W-1:0] INIT_WIDTH = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  rdSel_e            rdSel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              tickEn,
  input  logic              suppress,
  output logic [WORD_W-1:0] rdata,
  output logic              resetReq
);
  localparam logic [WORD_W-1:0] CTRL_CLR_MASK = ~(WORD_W'(4'hF) << 8);
  localparam logic [WORD_W-1:0] CTRL_SET_MASK = WORD_W'(1) << CTRL_TICK_BIT;

  logic [WORD_W-1:0]  countQ, reloadQ, ctrlQ, widthQ, maskQ;
  logic               runQ, pulseQ;
  logic [PULSE_W-1:0] pulseCntQ;

  logic              enNow, enNew, expire;
  logic [WORD_W-1:0] ctrlSan, widthNext;
  logic [7:0]        keyByte;

  assign enNow   = ctrlQ[CTRL_EN_BIT];
  assign ctrlSan = (wdata & CTRL_CLR_MASK) | CTRL_SET_MASK;
  assign enNew   = ctrlSan[CTRL_EN_BIT];
  assign expire  = runQ && (countQ == '0);
  assign keyByte = wdata[WORD_W-1 -: 8];

  always_comb begin
    widthNext = '0;
    widthNext[PULSE_W-1:0] = wdata[PULSE_W-1:0];
    case (keyByte)
      KEY_POL_HIGH: widthNext[POL_BIT] = 1'b1;
      KEY_POL_LOW:  widthNext[POL_BIT] = 1'b0;
      default:      widthNext[POL_BIT] = widthQ[POL_BIT];
    endcase
    case (keyByte)
      KEY_DRV_PUSH: widthNext[DRV_BIT] = 1'b1;
      KEY_DRV_OPEN: widthNext[DRV_BIT] = 1'b0;
      default:      widthNext[DRV_BIT] = widthQ[DRV_BIT];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= INIT_COUNT;
      reloadQ   <= INIT_COUNT;
      ctrlQ     <= '0;
      widthQ    <= INIT_WIDTH;
      maskQ     <= '0;
      runQ      <= 1'b0;
      pulseQ    <= 1'b0;
      pulseCntQ <= '0;
    end else begin
      if (stb.wrReload) reloadQ <= wdata;
      if (stb.wrMask)   maskQ   <= wdata;
      if (stb.wrWidth)  widthQ  <= widthNext;

      if (expire) begin
        runQ <= 1'b0;
        if (suppress) ctrlQ <= '0;
      end else if (runQ && tickEn) begin
        countQ <= countQ - 1'b1;
      end

      if (stb.kick) begin
        countQ <= reloadQ;
        if (enNow) runQ <= 1'b1;
      end

      if (stb.wrCtrl) begin
        ctrlQ <= ctrlSan;
        if (enNew && !enNow) begin
          countQ <= reloadQ;
          runQ   <= 1'b1;
        end else if (!enNew && enNow) begin
          runQ <= 1'b0;
        end
      end

      if (expire && !suppress) begin
        pulseQ    <= 1'b1;
        pulseCntQ <= widthQ[PULSE_W-1:0];
      end else if (pulseQ) begin
        if (pulseCntQ == '0) pulseQ <= 1'b0;
        else pulseCntQ <= pulseCntQ - 1'b1;
      end
    end
  end

  always_comb begin
    case (rdSel)
      SEL_COUNT:  rdata = countQ;
      SEL_RELOAD: rdata = reloadQ;
      SEL_CTRL:   rdata = ctrlQ;
      SEL_WIDTH:  rdata = widthQ;
      SEL_MASK:   rdata = maskQ;
      default:    rdata = '0;
    endcase
  end

  assign resetReq = widthQ[POL_BIT] ? pulseQ : !pulseQ;

  // R3: a keyed restart loads the reload value
  p_kick_loads_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.kick |=> (countQ == $past(reloadQ)));

  // R4: stored control value is sanitized
  p_ctrl_sanitized_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> (ctrlQ[11:8] == 4'h0 && ctrlQ[CTRL_TICK_BIT]));

  // R5: a stopped counter holds its value without a restart or control write
  p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !stb.kick && !stb.wrCtrl) |=> $stable(countQ));

  // R6: one step per tick while running
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && tickEn && countQ != '0 && !stb.kick && !stb.wrCtrl)
      |=> (countQ == $past(countQ) - 1'b1));

  // R7: a pulse only starts from an unsuppressed expiry
  p_pulse_from_expiry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseQ) |-> $past(expire && !suppress));

  // R8: a suppressed expiry starts no pulse
  p_suppress_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (expire && suppress && !pulseQ) |=> !pulseQ);

  // R9: width write keeps the written low bits
  p_width_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrWidth |=> (widthQ[PULSE_W-1:0] == $past(wdata[PULSE_W-1:0])));
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       PULSE_W    = 20,
  parameter logic [WORD_W-1:0] INIT_COUNT = 32'h03EF_1480,
  parameter logic [WORD_W-1:0] INIT_WIDTH = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickEn,
  input  logic              suppressReset,
  output logic              resetReq
);
  strobes_t stb;
  rdSel_e   rdSel;

  wdog_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .kickData (busWdata[15:0]),
    .stb      (stb),
    .rdSel    (rdSel)
  );

  wdog_datapath #(
    .PULSE_W    (PULSE_W),
    .INIT_COUNT (INIT_COUNT),
    .INIT_WIDTH (INIT_WIDTH)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .wdata    (busWdata),
    .tickEn   (tickEn),
    .suppress (suppressReset),
    .rdata    (busRdata),
    .resetReq (resetReq)
  );
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickEn = 1'b0, suppressReset = 1'b0;
  logic        resetReq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = !clk;

  wdog_top dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .suppressReset(suppressReset), .resetReq(resetReq)
  );

  // reference state built from the requirements
  logic [31:0] mCount, mReload, mCtrl, mWidth, mMask;
  logic        mRun, mPulse;
  logic [19:0] mPulseCnt;

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mCount;
      8'h04: return mReload;
      8'h0C: return mCtrl;
      8'h18: return mWidth;
      8'h1C: return mMask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    case (a)
      8'h00: return "R6";
      8'h0C: return "R4";
      8'h18: return "R9";
      8'h1C: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic        expire, enOld, enNew;
    logic [31:0] san, wnext;
    expire = mRun && (mCount == 0);
    enOld  = mCtrl[0];
    if (busValid && busWrite && busAddr == 8'h04) mReload = busWdata;
    if (busValid && busWrite && busAddr == 8'h1C) mMask = busWdata;
    if (busValid && busWrite && busAddr == 8'h18) begin
      wnext = {12'h0, busWdata[19:0]};
      wnext[31] = (busWdata[31:24] == 8'hA5) ? 1'b1 : (busWdata[31:24] == 8'h5A) ? 1'b0 : mWidth[31];
      wnext[30] = (busWdata[31:24] == 8'hA8) ? 1'b1 : (busWdata[31:24] == 8'h8A) ? 1'b0 : mWidth[30];
      mWidth = wnext;
    end
    // pulse uses the pre-write width
    if (expire && !suppressReset) begin
      mPulse = 1'b1; mPulseCnt = wnextWidthOld;
    end else if (mPulse) begin
      if (mPulseCnt == 0) mPulse = 1'b0; else mPulseCnt = mPulseCnt - 1;
    end
    if (expire) begin
      mRun = 1'b0;
      if (suppressReset) mCtrl = 32'h0;
    end else if (mRun && tickEn) mCount = mCount - 1;
    if (busValid && busWrite && busAddr == 8'h08 && busWdata[15:0] == 16'h4755) begin
      mCount = mReloadOld;
      if (enOld) mRun = 1'b1;
    end
    if (busValid && busWrite && busAddr == 8'h0C) begin
      san   = (busWdata & ~32'h0000_0F00) | 32'h10;
      enNew = san[0];
      mCtrl = san;
      if (enNew && !enOld) begin mCount = mReloadOld; mRun = 1'b1; end
      else if (!enNew && enOld) mRun = 1'b0;
    end
  endtask

  // values captured before this edge's writes
  logic [19:0] wnextWidthOld;
  logic [31:0] mReloadOld;

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 32'h03EF1480; mReload = 32'h03EF1480; mCtrl = 0;
      mWidth = 32'hFF; mMask = 0; mRun = 0; mPulse = 0; mPulseCnt = 0;
    end else begin
      wnextWidthOld = mWidth[19:0];
      mReloadOld    = mReload;
      modelStep();
    end
  end

  // one bus cycle: drive at negedge, check read and resetReq away from the edge
  task automatic cyc(input logic v, input logic w, input logic [7:0] a,
                     input logic [31:0] d, input logic t, input logic s, input string tag);
    @(negedge clk);
    check("R10 resetReq level (R7 pulse)", {31'h0, resetReq}, {31'h0, mWidth[31] ? mPulse : !mPulse});
    busValid = v; busWrite = w; busAddr = a; busWdata = d; tickEn = t; suppressReset = s;
    #1;
    if (v && !w) check(tag == "" ? reqOf(a) : tag, busRdata, expRead(a));
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 1'b0, tag);
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0, tag);
  endtask
  task automatic idle(input logic t, input logic s, input string tag);
    cyc(1'b0, 1'b0, 8'h00, 32'h0, t, s, tag);
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] addrs [10];
    logic [7:0] keys [6];
    logic [7:0] a;
    logic [31:0] d;
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h10, 8'h14, 8'h20, 8'hFC};
    keys  = '{8'hA5, 8'h5A, 8'hA8, 8'h8A, 8'h00, 8'h33};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h0C, "R1"); rd(8'h18, "R1");
    check("R1 idle resetReq", {31'h0, resetReq}, 32'h1);
    // R2 write-only and undefined
    rd(8'h08, "R2"); wr(8'h14, 32'hDEAD_BEEF, "R2"); rd(8'h14, "R2");
    wr(8'h00, 32'h1, "R2"); rd(8'h00, "R2");
    // R11 mask
    wr(8'h1C, 32'hA5A5_0F0F, "R11"); rd(8'h1C, "R11");
    // R3 restart key
    wr(8'h04, 32'd10, "R3"); wr(8'h08, 32'h0000_1234, "R3"); rd(8'h00, "R3");
    wr(8'h08, 32'hFFFF_4755, "R3"); rd(8'h00, "R3");
    // R4/R5 enable with reload 3, count, disable, hold
    wr(8'h04, 32'd3, "R5"); wr(8'h0C, 32'h0000_0F01, "R4"); rd(8'h0C, "R4");
    idle(1'b1, 1'b0, "R6"); rd(8'h00, "R6");
    wr(8'h0C, 32'h0, "R5"); idle(1'b1, 1'b0, "R5"); rd(8'h00, "R5");
    // R9 keyed width, R10 polarity, R7 pulse
    wr(8'h18, 32'hA5F0_0002, "R9"); rd(8'h18, "R9");
    wr(8'h18, 32'h3300_0002, "R9"); rd(8'h18, "R9");
    wr(8'h18, 32'hA800_0002, "R9"); rd(8'h18, "R9");
    wr(8'h04, 32'd1, "R7"); wr(8'h0C, 32'h1, "R7");
    repeat (8) idle(1'b1, 1'b0, "R7");
    // R8 suppressed expiry
    wr(8'h0C, 32'h0, "R8"); wr(8'h0C, 32'h1, "R8");
    repeat (4) idle(1'b1, 1'b1, "R8");
    rd(8'h0C, "R8");
    wr(8'h18, 32'h5A00_0001, "R10"); idle(1'b0, 1'b0, "R10");

    // random phase
    for (int i = 0; i < 20000; i++) begin
      a = addrs[$urandom_range(9)];
      d = $urandom;
      case (a)
        8'h04: d = d & 32'h1F;
        8'h08: if ($urandom_range(3) != 0) d = {d[31:16], 16'h4755};
        8'h18: d = {keys[$urandom_range(5)], 4'h0, d[19:3], 3'h0} | {29'h0, d[2:0]} & 32'hFF0F_FFFF;
        default: ;
      endcase
      if (a == 8'h18) d = {d[31:24], 4'h0, 17'h0, d[2:0]};
      if ($urandom_range(3) == 0)
        cyc(1'b1, $urandom_range(1) == 1, a, d, $urandom_range(3) != 0, $urandom_range(4) == 0, "");
      else
        idle($urandom_range(3) != 0, $urandom_range(4) == 0, "R6");
    end

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule